// File: doc/BRIEF.md
# Sensorless Back-EMF Event Sequencer

This block turns the sampled output of a back-EMF comparator into qualified motor events. It is used in a sensorless brushless drive. Each commutation pulse starts a new cycle. The block first looks for the end of demagnetization (D) on the undriven winding, and only after that for the back-EMF zero crossing (Z). The comparator is read only on a sample strobe, whose rate is set elsewhere in the drive. The block observes three comparator lines, one per phase. A select latched at commutation picks the line it uses.

Two mechanisms suppress false events. First, a blanking window after the commutation and after D skips a programmable number of strobes. Second, a consecutive-sample qualifier declares an event only after the chosen number of matching samples in a row. Separate polarity bits set the comparator level that counts as D and the level that counts as Z. After Z the block idles until the next commutation. Dropping the enable forces the block idle and suppresses all events.

Top module: `bemf_seq`

## Requirements
- R1: After reset, d_evt_o and z_evt_o are 0, state_o is 2'b00 (idle) and phase_o is 0.
- R2: With en_i high, a commutation pulse puts state_o to 2'b01 (seek D) on the next clock edge, from any state. It latches phase_sel_i into phase_o, clears the consecutive count and restarts blanking. A strobe in the same cycle is ignored. state_o never reads 2'b11.
- R3: While en_i is low, state_o goes to 2'b00, no D or Z pulse is produced and commutation pulses are ignored.
- R4: The comparator is evaluated only in cycles where strobe_i is high. Without a strobe, the state does not advance.
- R5: In seek D, a strobe qualifies when the selected comparator equals d_pol_i. After N consecutive qualifying strobes, where N is filt_lim_i (or 1 when filt_lim_i is 0), d_evt_o pulses in the cycle after the last strobe and state_o becomes 2'b10 (seek Z).
- R6: In seek Z, qualification uses z_pol_i. The qualifying strobe causes z_evt_o to pulse in the cycle after it, and state_o returns to 2'b00 until the next commutation.
- R7: A Z pulse occurs only from seek Z. A comparator level matching z_pol_i during seek D never produces Z.
- R8: A non-qualifying, unblanked strobe resets the consecutive count to zero.
- R9: After a commutation and after a D event, the next blank_len_i strobes are ignored. A length of 0 disables blanking.
- R10: phase_o values 0, 1 and 2 select comparator lines A, B and C. The value 3 selects none, and no strobe then qualifies.
- R11: d_evt_o and z_evt_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detector enable |
| strobe_i | input | 1 | Comparator sample strobe |
| commut_i | input | 1 | Commutation pulse |
| phase_sel_i | input | 2 | Phase select, latched at commutation |
| cmp_a_i | input | 1 | Comparator output, phase A |
| cmp_b_i | input | 1 | Comparator output, phase B |
| cmp_c_i | input | 1 | Comparator output, phase C |
| d_pol_i | input | 1 | Comparator level that qualifies D |
| z_pol_i | input | 1 | Comparator level that qualifies Z |
| blank_len_i | input | BLANK_W | Blanking length in strobes |
| filt_lim_i | input | FILT_W | Consecutive qualifying strobes required |
| d_evt_o | output | 1 | End of demagnetization pulse |
| z_evt_o | output | 1 | Zero crossing pulse |
| phase_o | output | 2 | Latched phase select |
| state_o | output | 2 | 00 idle, 01 seek D, 10 seek Z |

## Verification
On every cycle the assertions check the following. A commutation or a loss of enable forces the next state. Events follow a strobe. Z comes only from seek Z. The state that follows each event is correct. The pulses are exclusive and last one cycle. Only the bench scenarios can show the effects that depend on history. These are the count of strobes swallowed by blanking, the reset of the consecutive count by a mismatching sample, the effect of the filter limit, and the routing of the latched phase to the right comparator line. The bench checks these against its own cycle model under directed and random stimulus.

// File: rtl/bemf_seq_pkg.sv
package bemf_seq_pkg;
  localparam int unsigned NUM_PH = 3;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SEEK_D = 2'b01,
    ST_SEEK_Z = 2'b10
  } seq_st_e;
endpackage

// File: rtl/bemf_phase_mux.sv
module bemf_phase_mux #(
  parameter int unsigned NUM_PH = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [NUM_PH-1:0] cmp_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              cmp_o,
  output logic              valid_o
);
  always_comb begin
    cmp_o   = 1'b0;
    valid_o = 1'b0;
    for (int i = 0; i < NUM_PH; i++) begin
      if (sel_i == SEL_W'(i)) begin
        cmp_o   = cmp_i[i];
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bemf_blank.sv
module bemf_blank #(
  parameter int unsigned BLANK_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [BLANK_W-1:0] len_i,
  input  logic               step_i,
  output logic               busy_o
);
  logic [BLANK_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (load_i)           cnt_q <= len_i;
    else if (step_i && busy_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/bemf_qual.sv
module bemf_qual #(
  parameter int unsigned FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              hit_i,
  input  logic [FILT_W-1:0] lim_i,
  output logic              fire_o
);
  logic [FILT_W-1:0] cnt_q;
  logic [FILT_W:0]   cnt_nxt;
  logic [FILT_W-1:0] need;

  // limit 0 behaves as 1
  assign need    = (lim_i == '0) ? FILT_W'(1) : lim_i;
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign fire_o  = sample_i && hit_i && (cnt_nxt >= {1'b0, need});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (clr_i || fire_o)               cnt_q <= '0;
    else if (sample_i && !hit_i)            cnt_q <= '0;
    else if (sample_i && hit_i)             cnt_q <= cnt_nxt[FILT_W-1:0];
  end
endmodule

// File: rtl/bemf_seq.sv
module bemf_seq
  import bemf_seq_pkg::*;
#(
  parameter int unsigned BLANK_W = 4,
  parameter int unsigned FILT_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               strobe_i,
  input  logic               commut_i,
  input  logic [1:0]         phase_sel_i,
  input  logic               cmp_a_i,
  input  logic               cmp_b_i,
  input  logic               cmp_c_i,
  input  logic               d_pol_i,
  input  logic               z_pol_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  input  logic [FILT_W-1:0]  filt_lim_i,
  output logic               d_evt_o,
  output logic               z_evt_o,
  output logic [1:0]         phase_o,
  output logic [1:0]         state_o
);
  seq_st_e           st_q;
  logic [SEL_W-1:0]  ph_q;
  logic              d_q, z_q;
  logic [NUM_PH-1:0] cmp_vec;
  logic              cmp_sel, sel_ok;
  logic              go, searching, samp, use_s, hit, fire, blank_busy;

  assign cmp_vec   = {cmp_c_i, cmp_b_i, cmp_a_i};
  assign go        = en_i && commut_i;
  assign searching = (st_q == ST_SEEK_D) || (st_q == ST_SEEK_Z);
  assign samp      = en_i && strobe_i && searching && !go;
  assign use_s     = samp && !blank_busy;
  assign hit       = sel_ok && (cmp_sel == ((st_q == ST_SEEK_D) ? d_pol_i : z_pol_i));

  bemf_phase_mux #(.NUM_PH(NUM_PH), .SEL_W(SEL_W)) i_mux (
    .cmp_i   (cmp_vec),
    .sel_i   (ph_q),
    .cmp_o   (cmp_sel),
    .valid_o (sel_ok)
  );

  bemf_blank #(.BLANK_W(BLANK_W)) i_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_i),
    .load_i (go || (fire && st_q == ST_SEEK_D)),
    .len_i  (blank_len_i),
    .step_i (samp),
    .busy_o (blank_busy)
  );

  bemf_qual #(.FILT_W(FILT_W)) i_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (go || !en_i),
    .sample_i (use_s),
    .hit_i    (hit),
    .lim_i    (filt_lim_i),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
      d_q  <= 1'b0;
      z_q  <= 1'b0;
    end else begin
      d_q <= 1'b0;
      z_q <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else if (go) begin
        st_q <= ST_SEEK_D;
        ph_q <= phase_sel_i;
      end else if (fire) begin
        if (st_q == ST_SEEK_D) begin
          st_q <= ST_SEEK_Z;
          d_q  <= 1'b1;
        end else begin
          st_q <= ST_IDLE;
          z_q  <= 1'b1;
        end
      end
    end
  end

  assign d_evt_o = d_q;
  assign z_evt_o = z_q;
  assign phase_o = ph_q;
  assign state_o = st_q;
endmodule

// File: rtl/bemf_seq_chk.sv
module bemf_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       strobe_i,
  input logic       commut_i,
  input logic       d_evt_o,
  input logic       z_evt_o,
  input logic [1:0] state_o
);
  a_r2_commut_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && commut_i) |-> (state_o == 2'b01) && !d_evt_o && !z_evt_o);
  a_r2_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);
  a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (state_o == 2'b00) && !d_evt_o && !z_evt_o);
  a_r4_event_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_evt_o || z_evt_o) |-> $past(strobe_i));
  a_r5_d_to_seek_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_evt_o |-> (state_o == 2'b10) && ($past(state_o) == 2'b01));
  a_r6_z_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_evt_o |-> state_o == 2'b00);
  a_r7_z_needs_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_evt_o |-> $past(state_o) == 2'b10);
  a_r11_d_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_evt_o |=> !d_evt_o);
  a_r11_z_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_evt_o |=> !z_evt_o);
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(d_evt_o && z_evt_o));
endmodule

bind bemf_seq bemf_seq_chk i_chk (.*);

// File: tb/test_bemf_seq.sv
module test_bemf_seq;
  localparam int BW = 4;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, stb = 1'b0, com = 1'b0, dpol = 1'b1, zpol = 1'b0;
  logic [1:0] sel = '0;
  logic [2:0] cmp = '0;
  logic [BW-1:0] blen = '0;
  logic [FW-1:0] lim = '0;
  logic d_evt, z_evt;
  logic [1:0] phase, state;

  int n_chk = 0, n_bad = 0;
  bit seen_d = 0, seen_z = 0;

  // bench model
  int m_st = 0, m_blank = 0, m_cnt = 0, m_ph = 0, need;
  bit m_d = 0, m_z = 0, hit;

  always #2.5 clk = ~clk;

  bemf_seq #(.BLANK_W(BW), .FILT_W(FW)) i_bemf_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .strobe_i(stb), .commut_i(com),
    .phase_sel_i(sel), .cmp_a_i(cmp[0]), .cmp_b_i(cmp[1]), .cmp_c_i(cmp[2]),
    .d_pol_i(dpol), .z_pol_i(zpol), .blank_len_i(blen), .filt_lim_i(lim),
    .d_evt_o(d_evt), .z_evt_o(z_evt), .phase_o(phase), .state_o(state));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_blank = 0; m_cnt = 0; m_ph = 0; m_d = 0; m_z = 0;
    end else begin
      m_d = 0; m_z = 0;
      if (!en) begin
        m_st = 0; m_blank = 0; m_cnt = 0;
      end else if (com) begin
        m_st = 1; m_blank = int'(blen); m_cnt = 0; m_ph = int'(sel);
      end else if (stb && m_st != 0) begin
        if (m_blank > 0) m_blank--;
        else begin
          hit = (m_ph < 3) && (cmp[m_ph] == ((m_st == 1) ? dpol : zpol));
          need = (lim == 0) ? 1 : int'(lim);
          if (hit) begin
            m_cnt++;
            if (m_cnt >= need) begin
              m_cnt = 0;
              if (m_st == 1) begin m_d = 1; m_st = 2; m_blank = int'(blen); end
              else begin m_z = 1; m_st = 0; end
            end
          end else m_cnt = 0;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (d_evt) seen_d = 1;
    if (z_evt) seen_z = 1;
    check("R5", int'(d_evt), int'(m_d));
    check("R6", int'(z_evt), int'(m_z));
    check("R2", int'(state), m_st);
    check("R10", int'(phase), m_ph);
  endtask

  task automatic commut();
    com = 1'b1; cyc(); com = 1'b0;
  endtask

  task automatic strobe(logic [2:0] v);
    cmp = v; stb = 1'b1; cyc(); stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0B0F));
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(state), 0); check("R1", int'(d_evt), 0);
    check("R1", int'(z_evt), 0); check("R1", int'(phase), 0);

    // R3 commutation ignored while disabled
    en = 0; commut(); check("R3", int'(state), 0);
    en = 1; lim = 1; blen = 0; sel = 0;

    // R4 no strobe, no progress
    commut(); check("R2", int'(state), 1);
    cmp = 3'b111;
    for (int i = 0; i < 10; i++) cyc();
    check("R4", int'(state), 1); check("R4", int'(seen_d), 0);

    // R7 Z level in seek D does nothing
    seen_z = 0;
    for (int i = 0; i < 5; i++) strobe(3'b000);
    check("R7", int'(seen_z), 0); check("R7", int'(state), 1);

    strobe(3'b111); check("R5", int'(d_evt), 1); check("R5", int'(state), 2);
    cyc(); check("R11", int'(d_evt), 0);
    strobe(3'b000); check("R6", int'(z_evt), 1); check("R6", int'(state), 0);
    cyc(); check("R11", int'(z_evt), 0);

    // R9 blanking of two strobes after C and after D
    blen = 2; commut(); seen_d = 0; seen_z = 0;
    strobe(3'b111); strobe(3'b111);
    check("R9", int'(seen_d), 0); check("R9", int'(state), 1);
    strobe(3'b111); check("R9", int'(d_evt), 1);
    strobe(3'b000); strobe(3'b000);
    check("R9", int'(seen_z), 0); check("R9", int'(state), 2);
    strobe(3'b000); check("R9", int'(z_evt), 1);

    // R8 mismatch restarts the count
    blen = 0; lim = 3; commut(); seen_d = 0;
    strobe(3'b111); strobe(3'b111); strobe(3'b000); strobe(3'b111); strobe(3'b111);
    check("R8", int'(seen_d), 0); check("R8", int'(state), 1);
    strobe(3'b111); check("R8", int'(d_evt), 1);

    // R10 invalid select never qualifies, phase C routing
    lim = 1; sel = 3; commut(); seen_d = 0;
    strobe(3'b111); strobe(3'b000); strobe(3'b111);
    check("R10", int'(seen_d), 0); check("R10", int'(phase), 3);
    sel = 2; commut(); check("R10", int'(phase), 2);
    strobe(3'b011); check("R10", int'(d_evt), 0);
    strobe(3'b100); check("R10", int'(d_evt), 1);

    // random stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      en   = ($urandom_range(0, 39) != 0);
      com  = ($urandom_range(0, 29) == 0);
      stb  = ($urandom_range(0, 2) == 0);
      cmp  = 3'($urandom());
      if ($urandom_range(0, 49) == 0) begin
        sel  = 2'($urandom());
        blen = BW'($urandom_range(0, 3));
        lim  = FW'($urandom_range(0, 3));
        dpol = 1'($urandom());
        zpol = 1'($urandom());
      end
      cyc();
    end
    com = 0; stb = 0;
    finish_run();
  end
endmodule